// File: doc/BRIEF.md
# Windowed Watchdog Timer with Configuration Locks

This block is a supervisory down-counter. Software must service it before a programmable timeout runs out, or it raises a request to the system. Software reaches it through a small register port. A write carries a target address, a data word and the identity of the bus master making the write. The counter can run on every system clock cycle, or only on cycles that carry a pulse from a slower oscillator. The oscillator pulse has already been brought into the system clock domain.

Servicing is a two-word key sequence written to the service register. In window mode, a service is legal only once the counter has fallen to the programmed window value or below. A missed timeout or a bad access escalates in one of two ways. Either the block raises a reset request straight away, or it first raises an interrupt and reloads, and raises the reset request only if the next escalation comes while that interrupt is still pending.

Configuration can be frozen in three ways. A soft lock can be lifted by a second key sequence. A hard lock holds until the next reset. Master-ID protection rejects writes from any other master. A strap input chooses whether the watchdog is already running when reset ends.

Top module: `wdog_top`

## Requirements
- R1: During reset the control word becomes zero except bit 0 (enable), which takes the value of `boot_en`. The timeout register and the counter take the `TO_RESET` value, the window register becomes zero, and `irq_req` and `rst_req` are low.
- R2: While enabled, the counter decreases by one on each tick. With control bit 1 (oscillator select) clear, every clock cycle is a tick. With it set, only cycles with `osc_tick` high are ticks.
- R3: With control bit 3 (interrupt-first) clear, a tick that finds the counter at zero sets `rst_req` on the following edge. `rst_req` then stays high until reset.
- R4: With control bit 3 set, the first escalation sets `irq_req` and reloads the counter from the timeout register. An escalation that arrives while `irq_req` is still high sets `rst_req`.
- R5: Writing 16'hA602 and then 16'hB480 to the service register (address 3, low 16 bits) reloads the counter from the timeout register and clears `irq_req`.
- R6: Any other value written to the service register, or either key out of order, is an invalid access. An invalid access while enabled escalates as in R3/R4.
- R7: With control bit 2 (window mode) set, a completed key sequence while the counter is above the window register (address 2) is an invalid access. At or below the window value the service is valid.
- R8: With control bit 4 (protection) set, a write from a master whose `bus_mid` differs from control bits [11:8] changes nothing. If the watchdog is enabled, that write is an invalid access.
- R9: With control bit 5 (soft lock) set, writes to the control, timeout (address 1) and window registers are ignored. Writing 16'hC520 and then 16'hD928 to the service register clears the soft lock.
- R10: With control bit 6 (hard lock) set, writes to the control, timeout and window registers are ignored, and the unlock sequence does not clear the hard lock. Only reset clears it.
- R11: A control write that changes bit 0 from 0 to 1 loads the counter from the timeout register. While disabled, the counter holds and no escalation occurs.
- R12: If a valid service completes on the same edge at which the counter would expire, the service wins and no escalation happens. Several escalation causes on one edge count as a single escalation step.
- R13: Reading address 4 returns the live counter value. Reads of addresses 0, 1 and 2 return the control word, the timeout and the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_en | input | 1 | Strap: watchdog enabled when reset ends |
| osc_tick | input | 1 | Oscillator tick, synchronous to clk |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | W | Write data |
| bus_mid | input | 4 | Identity of the writing master |
| bus_rdata | output | W | Read data for bus_addr (combinational) |
| irq_req | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request (sticky) |

## Verification
Three things can land on the same edge: expiry, a service completion, and an invalid access. The bench lines up the second service key so that it arrives exactly on the tick where the counter sits at zero. It then expects a reload with no request raised. It also places a bad service word on the expiry edge in interrupt-first mode. There it expects only the interrupt, with `rst_req` still low, which shows that the two causes were merged into one escalation step.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int MID_W  = 4;
    localparam int CTRL_W = 12;

    // register map
    localparam logic [2:0] AD_CTRL = 3'd0;
    localparam logic [2:0] AD_TMO  = 3'd1;
    localparam logic [2:0] AD_WIN  = 3'd2;
    localparam logic [2:0] AD_SVC  = 3'd3;
    localparam logic [2:0] AD_CNT  = 3'd4;

    // key words on the service register
    localparam logic [15:0] KEY_SVC_A = 16'hA602;
    localparam logic [15:0] KEY_SVC_B = 16'hB480;
    localparam logic [15:0] KEY_UNL_A = 16'hC520;
    localparam logic [15:0] KEY_UNL_B = 16'hD928;

    typedef struct packed {
        logic [MID_W-1:0] mid;
        logic             hard_lock;
        logic             soft_lock;
        logic             prot_en;
        logic             irq_first;
        logic             win_en;
        logic             osc_sel;
        logic             enable;
    } ctrl_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SVC  = 2'd1,
        SQ_UNL  = 2'd2
    } seq_e;

    function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.enable    = w[0];
        c.osc_sel   = w[1];
        c.win_en    = w[2];
        c.irq_first = w[3];
        c.prot_en   = w[4];
        c.soft_lock = w[5];
        c.hard_lock = w[6];
        c.mid       = w[11:8];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        return {c.mid, 1'b0, c.hard_lock, c.soft_lock, c.prot_en,
                c.irq_first, c.win_en, c.osc_sel, c.enable};
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          W        = 32,
    parameter logic [W-1:0] TO_RESET = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_en,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [W-1:0]     bus_wdata,
    input  logic [MID_W-1:0] bus_mid,
    input  logic             unlock_done,
    output ctrl_t            cfg,
    output logic [W-1:0]     tmo,
    output logic [W-1:0]     win,
    output logic             start,
    output logic             prot_bad,
    output logic             svc_wr
);

    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] tmo;
        logic [W-1:0] win;
    } reg_st_t;

    reg_st_t q, d;

    logic acc_ok;
    logic wr_ok;
    logic locked;

    assign acc_ok   = !q.ctrl.prot_en || (bus_mid == q.ctrl.mid);
    assign wr_ok    = bus_wr && acc_ok;
    assign locked   = q.ctrl.soft_lock || q.ctrl.hard_lock;
    assign prot_bad = bus_wr && !acc_ok;
    assign svc_wr   = wr_ok && (bus_addr == AD_SVC);

    always_comb begin
        ctrl_t nc;
        d     = q;
        start = 1'b0;
        nc    = ctrl_unpack(bus_wdata[CTRL_W-1:0]);
        if (wr_ok && !locked) begin
            case (bus_addr)
                AD_CTRL: begin
                    d.ctrl = nc;
                    start  = nc.enable && !q.ctrl.enable;
                end
                AD_TMO:  d.tmo = bus_wdata;
                AD_WIN:  d.win = bus_wdata;
                default: ;
            endcase
        end
        if (unlock_done) begin
            d.ctrl.soft_lock = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ctrl        <= '0;
            q.ctrl.enable <= boot_en;
            q.tmo         <= TO_RESET;
            q.win         <= '0;
        end else begin
            q <= d;
        end
    end

    assign cfg = q.ctrl;
    assign tmo = q.tmo;
    assign win = q.win;

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr,
    input  logic [15:0] key,
    output logic        svc_done,
    output logic        unl_done,
    output logic        seq_bad
);

    typedef struct packed {
        seq_e st;
    } seq_st_t;

    seq_st_t q, d;

    always_comb begin
        d        = q;
        svc_done = 1'b0;
        unl_done = 1'b0;
        seq_bad  = 1'b0;
        if (svc_wr) begin
            case (q.st)
                SQ_IDLE: begin
                    if (key == KEY_SVC_A) begin
                        d.st = SQ_SVC;
                    end else if (key == KEY_UNL_A) begin
                        d.st = SQ_UNL;
                    end else begin
                        seq_bad = 1'b1;
                    end
                end
                SQ_SVC: begin
                    d.st = SQ_IDLE;
                    if (key == KEY_SVC_B) svc_done = 1'b1;
                    else                  seq_bad  = 1'b1;
                end
                SQ_UNL: begin
                    d.st = SQ_IDLE;
                    if (key == KEY_UNL_B) unl_done = 1'b1;
                    else                  seq_bad  = 1'b1;
                end
                default: begin
                    d.st    = SQ_IDLE;
                    seq_bad = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.st <= SQ_IDLE;
        else        q    <= d;
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int          W        = 32,
    parameter logic [W-1:0] TO_RESET = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         osc_sel,
    input  logic         win_en,
    input  logic         irq_first,
    input  logic         osc_tick,
    input  logic [W-1:0] tmo,
    input  logic [W-1:0] win,
    input  logic         start,
    input  logic         svc_done,
    input  logic         bad_in,
    output logic [W-1:0] cnt,
    output logic         irq,
    output logic         rst
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq;
        logic         rst;
    } core_st_t;

    core_st_t q, d;

    logic tick, win_bad, good, bad, expire, evt;

    always_comb begin
        d       = q;
        tick    = osc_sel ? osc_tick : 1'b1;
        win_bad = svc_done && win_en && (q.cnt > win);
        good    = en && svc_done && !win_bad;
        bad     = en && (bad_in || win_bad);
        expire  = en && tick && (q.cnt == '0) && !good;
        evt     = bad || expire;
        if (start) begin
            d.cnt = tmo;
        end else if (en) begin
            if (good) begin
                d.cnt = tmo;
                d.irq = 1'b0;
            end else if (evt) begin
                if (irq_first && !q.irq) begin
                    d.irq = 1'b1;
                    d.cnt = tmo;
                end else begin
                    d.rst = 1'b1;
                end
            end else if (tick) begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt <= TO_RESET;
            q.irq <= 1'b0;
            q.rst <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cnt = q.cnt;
    assign irq = q.irq;
    assign rst = q.rst;

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int          W        = 32,
    parameter logic [W-1:0] TO_RESET = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_en,
    input  logic             osc_tick,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [W-1:0]     bus_wdata,
    input  logic [MID_W-1:0] bus_mid,
    output logic [W-1:0]     bus_rdata,
    output logic             irq_req,
    output logic             rst_req
);

    ctrl_t        cfg;
    logic [W-1:0] tmo_w, win_w, cnt_w;
    logic         start_w, prot_bad_w, svc_wr_w;
    logic         svc_done_w, unl_done_w, seq_bad_w;
    logic         cfg_en, cfg_irqf, cfg_hard;

    wdog_regs #(.W(W), .TO_RESET(TO_RESET)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_en     (boot_en),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_mid     (bus_mid),
        .unlock_done (unl_done_w),
        .cfg         (cfg),
        .tmo         (tmo_w),
        .win         (win_w),
        .start       (start_w),
        .prot_bad    (prot_bad_w),
        .svc_wr      (svc_wr_w)
    );

    wdog_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr   (svc_wr_w),
        .key      (bus_wdata[15:0]),
        .svc_done (svc_done_w),
        .unl_done (unl_done_w),
        .seq_bad  (seq_bad_w)
    );

    wdog_core #(.W(W), .TO_RESET(TO_RESET)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg.enable),
        .osc_sel   (cfg.osc_sel),
        .win_en    (cfg.win_en),
        .irq_first (cfg.irq_first),
        .osc_tick  (osc_tick),
        .tmo       (tmo_w),
        .win       (win_w),
        .start     (start_w),
        .svc_done  (svc_done_w),
        .bad_in    (prot_bad_w || seq_bad_w),
        .cnt       (cnt_w),
        .irq       (irq_req),
        .rst       (rst_req)
    );

    assign cfg_en   = cfg.enable;
    assign cfg_irqf = cfg.irq_first;
    assign cfg_hard = cfg.hard_lock;

    always_comb begin
        case (bus_addr)
            AD_CTRL: bus_rdata = {{(W-CTRL_W){1'b0}}, ctrl_pack(cfg)};
            AD_TMO:  bus_rdata = tmo_w;
            AD_WIN:  bus_rdata = win_w;
            AD_CNT:  bus_rdata = cnt_w;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         start,
    input logic         irq_first,
    input logic         hard,
    input logic [W-1:0] cnt,
    input logic [W-1:0] tmo,
    input logic         irq_req,
    input logic         rst_req
);

    // R1: requests are low in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_req && !rst_req));

    // R2: the counter only holds, steps down by one, or reloads
    a_r2_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1 || cnt == $past(tmo)));

    // R3: the reset request is sticky
    a_r3_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R4: an interrupt can only appear in interrupt-first mode
    a_r4_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(irq_first));

    // R10: hard lock never clears outside reset
    a_r10_hard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hard |=> hard);

    // R11: a disabled counter holds its value
    a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !start) |=> $stable(cnt));

endmodule

bind wdog_top wdog_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .start     (start_w),
    .irq_first (cfg_irqf),
    .hard      (cfg_hard),
    .cnt       (cnt_w),
    .tmo       (tmo_w),
    .irq_req   (irq_req),
    .rst_req   (rst_req)
);

// File: tb/tb_wdog_top.sv
module tb_wdog_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 32;
    localparam logic [31:0] TO_RST     = 32'd256;
    localparam int          NTBL       = 19;

    // entry: {rd, addr[2:0], data[31:0], mid[3:0], exp[31:0], req[7:0]}
    localparam logic [79:0] TBL [NTBL] = '{
        {1'b1, 3'd0, 32'h0,    4'd0, 32'h0,    8'd1},  // R1 ctrl
        {1'b1, 3'd1, 32'h0,    4'd0, TO_RST,   8'd1},  // R1 timeout
        {1'b0, 3'd1, 32'd5,    4'd0, 32'h0,    8'd13},
        {1'b1, 3'd1, 32'h0,    4'd0, 32'd5,    8'd13}, // R13
        {1'b0, 3'd2, 32'd3,    4'd0, 32'h0,    8'd13},
        {1'b1, 3'd2, 32'h0,    4'd0, 32'd3,    8'd13},
        {1'b0, 3'd0, 32'h20,   4'd0, 32'h0,    8'd9},  // R9 soft lock
        {1'b0, 3'd1, 32'd9,    4'd0, 32'h0,    8'd9},
        {1'b1, 3'd1, 32'h0,    4'd0, 32'd5,    8'd9},
        {1'b0, 3'd3, 32'hC520, 4'd0, 32'h0,    8'd9},
        {1'b0, 3'd3, 32'hD928, 4'd0, 32'h0,    8'd9},
        {1'b1, 3'd0, 32'h0,    4'd0, 32'h0,    8'd9},
        {1'b0, 3'd0, 32'h710,  4'd0, 32'h0,    8'd8},  // R8 protection
        {1'b0, 3'd1, 32'd8,    4'd2, 32'h0,    8'd8},
        {1'b1, 3'd1, 32'h0,    4'd0, 32'd5,    8'd8},
        {1'b0, 3'd1, 32'd6,    4'd7, 32'h0,    8'd8},
        {1'b1, 3'd1, 32'h0,    4'd0, 32'd6,    8'd8},
        {1'b0, 3'd0, 32'h0,    4'd7, 32'h0,    8'd8},
        {1'b1, 3'd0, 32'h0,    4'd0, 32'h0,    8'd8}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         boot_en = 1'b0;
    logic         osc_tick = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [3:0]   bus_mid = '0;
    logic [W-1:0] bus_rdata;
    logic         irq_req, rst_req;

    int checks = 0;
    int errors = 0;

    wdog_top #(.W(W), .TO_RESET(TO_RST)) dut (
        .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .osc_tick(osc_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_mid(bus_mid), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] dat, input logic [3:0] m);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = dat; bus_mid = m;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic boot);
        rst_n = 1'b0; boot_en = boot; osc_tick = 1'b0; bus_wr = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        chk("R1 irq", {31'b0, irq_req}, 32'd0);
        chk("R1 rst", {31'b0, rst_req}, 32'd0);

        // table of register accesses with the counter stopped
        for (int i = 0; i < NTBL; i++) begin
            if (TBL[i][79]) begin
                rd(TBL[i][78:76], TBL[i][39:8], $sformatf("R%0d table %0d", TBL[i][7:0], i));
            end else begin
                wr(TBL[i][78:76], TBL[i][75:44], TBL[i][43:40]);
            end
        end

        // R1/R13/R2: boot-enabled counter runs from the reset value
        do_reset(1'b1);
        rd(3'd0, 32'h1, "R1 boot enable");
        rd(3'd4, TO_RST, "R13 count at reset");
        wait_n(3);
        rd(3'd4, TO_RST - 3, "R2 sys tick");

        // R3: expiry in reset mode
        do_reset(1'b0);
        wr(3'd1, 32'd4, 4'd0);
        wr(3'd0, 32'h1, 4'd0);
        wait_n(4);
        rd(3'd4, 32'd0, "R11 load then count");
        chk("R3 before expiry", {31'b0, rst_req}, 32'd0);
        wait_n(1);
        chk("R3 expiry", {31'b0, rst_req}, 32'd1);
        wait_n(3);
        chk("R3 sticky", {31'b0, rst_req}, 32'd1);

        // R11: disabled counter holds
        do_reset(1'b0);
        wr(3'd1, 32'd4, 4'd0);
        wait_n(10);
        rd(3'd4, TO_RST, "R11 hold");
        chk("R11 no event", {31'b0, rst_req}, 32'd0);

        // R2: oscillator ticks
        do_reset(1'b0);
        wr(3'd1, 32'd10, 4'd0);
        wr(3'd0, 32'h3, 4'd0);
        wait_n(5);
        rd(3'd4, 32'd10, "R2 osc idle");
        osc_tick = 1'b1;
        wait_n(3);
        osc_tick = 1'b0;
        rd(3'd4, 32'd7, "R2 osc ticks");

        // R4: interrupt then reset
        do_reset(1'b0);
        wr(3'd1, 32'd3, 4'd0);
        wr(3'd0, 32'h9, 4'd0);
        wait_n(4);
        chk("R4 irq", {31'b0, irq_req}, 32'd1);
        chk("R4 no rst yet", {31'b0, rst_req}, 32'd0);
        rd(3'd4, 32'd3, "R4 reload");
        wait_n(4);
        chk("R4 second expiry", {31'b0, rst_req}, 32'd1);

        // R5: service reload
        do_reset(1'b0);
        wr(3'd1, 32'd6, 4'd0);
        wr(3'd0, 32'h1, 4'd0);
        wait_n(2);
        wr(3'd3, 32'hA602, 4'd0);
        wr(3'd3, 32'hB480, 4'd0);
        rd(3'd4, 32'd6, "R5 reload");
        do_reset(1'b0);
        wr(3'd1, 32'd3, 4'd0);
        wr(3'd0, 32'h9, 4'd0);
        wait_n(4);
        wr(3'd3, 32'hA602, 4'd0);
        wr(3'd3, 32'hB480, 4'd0);
        chk("R5 irq cleared", {31'b0, irq_req}, 32'd0);
        rd(3'd4, 32'd3, "R5 reload irq mode");

        // R6: bad value and wrong order
        do_reset(1'b0);
        wr(3'd1, 32'd20, 4'd0);
        wr(3'd0, 32'h1, 4'd0);
        wr(3'd3, 32'h1234, 4'd0);
        chk("R6 bad key", {31'b0, rst_req}, 32'd1);
        do_reset(1'b0);
        wr(3'd1, 32'd20, 4'd0);
        wr(3'd0, 32'h9, 4'd0);
        wr(3'd3, 32'hB480, 4'd0);
        chk("R6 wrong order irq", {31'b0, irq_req}, 32'd1);
        chk("R6 wrong order no rst", {31'b0, rst_req}, 32'd0);

        // R7: window
        do_reset(1'b0);
        wr(3'd1, 32'd10, 4'd0);
        wr(3'd2, 32'd4, 4'd0);
        wr(3'd0, 32'h5, 4'd0);
        wr(3'd3, 32'hA602, 4'd0);
        wr(3'd3, 32'hB480, 4'd0);
        chk("R7 early service", {31'b0, rst_req}, 32'd1);
        do_reset(1'b0);
        wr(3'd1, 32'd10, 4'd0);
        wr(3'd2, 32'd4, 4'd0);
        wr(3'd0, 32'h5, 4'd0);
        wait_n(5);
        wr(3'd3, 32'hA602, 4'd0);
        wr(3'd3, 32'hB480, 4'd0);
        chk("R7 in window", {31'b0, rst_req}, 32'd0);
        rd(3'd4, 32'd10, "R7 reload");

        // R8: foreign master while enabled
        do_reset(1'b0);
        wr(3'd1, 32'd50, 4'd0);
        wr(3'd0, 32'h711, 4'd0);
        wr(3'd1, 32'd9, 4'd3);
        chk("R8 invalid access", {31'b0, rst_req}, 32'd1);
        rd(3'd1, 32'd50, "R8 ignored");

        // R10: hard lock
        do_reset(1'b0);
        wr(3'd0, 32'h40, 4'd0);
        wr(3'd1, 32'd9, 4'd0);
        rd(3'd1, TO_RST, "R10 write ignored");
        wr(3'd3, 32'hC520, 4'd0);
        wr(3'd3, 32'hD928, 4'd0);
        rd(3'd0, 32'h40, "R10 unlock no effect");
        do_reset(1'b0);
        rd(3'd0, 32'h0, "R10 cleared by reset");

        // R12: service on the expiry edge
        do_reset(1'b0);
        wr(3'd1, 32'd3, 4'd0);
        wr(3'd0, 32'h1, 4'd0);
        wait_n(2);
        wr(3'd3, 32'hA602, 4'd0);
        wr(3'd3, 32'hB480, 4'd0);
        chk("R12 service wins", {31'b0, rst_req}, 32'd0);
        rd(3'd4, 32'd3, "R12 reload");
        wait_n(4);
        chk("R12 later expiry", {31'b0, rst_req}, 32'd1);

        // R12: invalid access and expiry merge into one step
        do_reset(1'b0);
        wr(3'd1, 32'd3, 4'd0);
        wr(3'd0, 32'h9, 4'd0);
        wait_n(3);
        wr(3'd3, 32'h1, 4'd0);
        chk("R12 single step irq", {31'b0, irq_req}, 32'd1);
        chk("R12 single step rst", {31'b0, rst_req}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule